// File: doc/BRIEF.md
# Iterative Ascon Permutation Round Unit

This block applies the Ascon permutation to a 320-bit state. The state is five 64-bit words, and the block computes one round per clock. A caller presents a state and a round-count code, then pulses `start`. The block then runs the requested number of rounds: 12, 8 or 6. Each round does three things in order:

1. It XORs an 8-bit round constant into word 2.
2. It passes every bit slice of the five words through a 5-bit substitution box.
3. It mixes each word with two right rotations of itself.

The round constants come from two 4-bit counters, not from a table. The low nibble counts up and the high nibble counts down. A shortened run starts part-way through the 12-round schedule, so it always uses the final constants.

The state machine has three states:
- **IDLE** waits for `start` (transition *accept*: go to RUN).
- **RUN** applies one round per cycle (transition *step*: stay in RUN; transition *last*: when the constant index reaches 11, go to FIN).
- **FIN** raises `done` for one cycle. From FIN, *accept* goes to RUN if `start` is high, and *retire* goes to IDLE otherwise.

`state_out` always shows the working register. It therefore holds the final result from FIN until the next accepted start.

Top module: `ascon_perm_iter`

## Requirements
- R1: After reset, `done` is 0 and `state_out` is all zeros.
- R2: Word i of the state is bits [64*i+63 : 64*i] of `state_in` and `state_out`. A `start` seen in IDLE or FIN loads `state_in` into the working state, and the rounds begin on the next cycle, one round per cycle.
- R3: `round_sel` selects the round count: 2'b00 gives 12, 2'b01 gives 8, 2'b10 gives 6, and 2'b11 gives 12.
- R4: The round with index r (0 to 11) XORs ((15-r)<<4)|r into bits [7:0] of word 2. A run of N rounds uses indices 12-N to 11.
- R5: The substitution maps each slice {w0[b],w1[b],w2[b],w3[b],w4[b]} (w0 as the MSB) through the table 4,11,31,20,26,21,9,2,27,5,8,18,29,3,6,28,30,19,7,14,0,13,17,24,16,12,1,25,22,10,15,23.
- R6: The diffusion step sets each word to w ^ ror(w,a) ^ ror(w,b), with right rotations (a,b) of (19,28), (61,39), (1,6), (10,17) and (7,41) for words 0 to 4.
- R7: `done` is high for exactly one cycle, N clock edges after the edge that accepted `start`.
- R8: After `done`, `state_out` holds its value until the next accepted `start`, whatever `state_in` does.
- R9: `start` is ignored while rounds are running. It neither reloads the state nor changes the round count.
- R10: A `start` presented during the `done` cycle is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a permutation run |
| round_sel | input | 2 | Round-count code |
| state_in | input | 320 | State loaded on an accepted start |
| state_out | output | 320 | Working state; the result once done |
| done | output | 1 | One-cycle pulse after the last round |

## Verification
The *last* transition's `done` pulse and the *accept* of a new `start` can fall in the same cycle. The bench provokes this by driving `start` with a fresh state at the moment it observes `done`. It judges the outcome three ways: the new run must finish after exactly its own round count, the FIN result must be visible for that one cycle, and the cycle-by-cycle reference model must agree. The bench also fires `start` in the middle of a run to show that the running permutation is undisturbed.

// File: rtl/ascon_perm_pkg.sv
package ascon_perm_pkg;
    localparam int NUM_WORDS = 5;
    localparam int CNT_W     = 4;
    localparam int RC_W      = 2 * CNT_W;
    localparam logic [CNT_W-1:0] LAST_IDX = 4'd11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } fsm_t;

    // round count selected by the 2-bit code
    function automatic logic [CNT_W-1:0] rounds_of(input logic [1:0] code);
        unique case (code)
            2'b01:   rounds_of = 4'd8;
            2'b10:   rounds_of = 4'd6;
            default: rounds_of = 4'd12;
        endcase
    endfunction
endpackage

// File: rtl/ascon_rc_gen.sv
module ascon_rc_gen
    import ascon_perm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] first_idx,
    output logic [RC_W-1:0]  rc,
    output logic             last
);
    logic [CNT_W-1:0] up_q, down_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q   <= '0;
            down_q <= '1;
        end else if (load) begin
            up_q   <= first_idx;
            down_q <= 4'd15 - first_idx;
        end else if (step) begin
            up_q   <= up_q + 4'd1;
            down_q <= down_q + 4'hF;
        end
    end

    assign rc   = {down_q, up_q};
    assign last = (up_q == LAST_IDX);

    // R4
    rc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, up_q} + {1'b0, down_q}) == 5'd15);
endmodule

// File: rtl/ascon_sbox5.sv
module ascon_sbox5 (
    input  logic [4:0] x,
    output logic [4:0] y
);
    logic a0, a1, a2, a3, a4;
    logic b0, b1, b2, b3, b4;
    logic t0, t1, t2, t3, t4;

    always_comb begin
        a0 = x[4] ^ x[0];
        a1 = x[3];
        a2 = x[2] ^ x[3];
        a3 = x[1];
        a4 = x[0] ^ x[1];
        t0 = ~a0 & a1;
        t1 = ~a1 & a2;
        t2 = ~a2 & a3;
        t3 = ~a3 & a4;
        t4 = ~a4 & a0;
        b0 = a0 ^ t1;
        b1 = a1 ^ t2;
        b2 = a2 ^ t3;
        b3 = a3 ^ t4;
        b4 = a4 ^ t0;
        y[3] = b1 ^ b0;
        y[4] = b0 ^ b4;
        y[1] = b3 ^ b2;
        y[2] = ~b2;
        y[0] = b4;
    end
endmodule

// File: rtl/ascon_lindiff.sv
module ascon_lindiff #(
    parameter int WORD_W = 64,
    parameter int ROT_A  = 19,
    parameter int ROT_B  = 28
) (
    input  logic [WORD_W-1:0] w_in,
    output logic [WORD_W-1:0] w_out
);
    logic [WORD_W-1:0] ra, rb;
    assign ra    = (w_in >> ROT_A) | (w_in << (WORD_W - ROT_A));
    assign rb    = (w_in >> ROT_B) | (w_in << (WORD_W - ROT_B));
    assign w_out = w_in ^ ra ^ rb;
endmodule

// File: rtl/ascon_perm_iter.sv
module ascon_perm_iter
    import ascon_perm_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [1:0]                    round_sel,
    input  logic [NUM_WORDS*WORD_W-1:0]   state_in,
    output logic [NUM_WORDS*WORD_W-1:0]   state_out,
    output logic                          done
);
    localparam int STATE_W = NUM_WORDS * WORD_W;
    localparam int ROT_A [NUM_WORDS] = '{19, 61, 1, 10, 7};
    localparam int ROT_B [NUM_WORDS] = '{28, 39, 6, 17, 41};

    fsm_t               fsm_q, fsm_d;
    logic [STATE_W-1:0] st_q, st_next;
    logic               accept, running, last;
    logic [RC_W-1:0]    rc;
    logic [CNT_W-1:0]   first_idx;

    assign running   = (fsm_q == ST_RUN);
    assign accept    = start && !running;
    assign first_idx = 4'd12 - rounds_of(round_sel);

    ascon_rc_gen u_rc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (running),
        .first_idx (first_idx),
        .rc        (rc),
        .last      (last)
    );

    // round datapath: constant, substitution, diffusion
    logic [WORD_W-1:0] w_c  [NUM_WORDS];
    logic [WORD_W-1:0] w_s  [NUM_WORDS];
    logic [WORD_W-1:0] w_l  [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_const
        if (i == 2) begin : g_add
            assign w_c[i] = st_q[i*WORD_W +: WORD_W] ^ {{(WORD_W-RC_W){1'b0}}, rc};
        end else begin : g_pass
            assign w_c[i] = st_q[i*WORD_W +: WORD_W];
        end
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_slice
        logic [4:0] sx, sy;
        assign sx = {w_c[0][b], w_c[1][b], w_c[2][b], w_c[3][b], w_c[4][b]};
        ascon_sbox5 u_sb (.x(sx), .y(sy));
        assign w_s[0][b] = sy[4];
        assign w_s[1][b] = sy[3];
        assign w_s[2][b] = sy[2];
        assign w_s[3][b] = sy[1];
        assign w_s[4][b] = sy[0];
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_diff
        ascon_lindiff #(.WORD_W(WORD_W), .ROT_A(ROT_A[i]), .ROT_B(ROT_B[i])) u_ld (
            .w_in  (w_s[i]),
            .w_out (w_l[i])
        );
        assign st_next[i*WORD_W +: WORD_W] = w_l[i];
    end

    // next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE: if (start) fsm_d = ST_RUN;
            ST_RUN:  if (last)  fsm_d = ST_FIN;
            ST_FIN:  fsm_d = start ? ST_RUN : ST_IDLE;
            default: fsm_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= ST_IDLE;
            st_q  <= '0;
        end else begin
            fsm_q <= fsm_d;
            if (accept)       st_q <= state_in;
            else if (running) st_q <= st_next;
        end
    end

    // outputs
    always_comb begin
        done      = (fsm_q == ST_FIN);
        state_out = st_q;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q != ST_RUN && !start) |=> $stable(state_out));
    // R9
    run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !last) |=> (fsm_q == ST_RUN));
    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (fsm_q == ST_RUN));
endmodule

// File: tb/sim_ascon_perm_iter.sv
module sim_ascon_perm_iter;
    localparam int W = 64;
    localparam int SW = 5 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    round_sel = 2'b00;
    logic [SW-1:0] state_in = '0;
    logic [SW-1:0] state_out;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ascon_perm_iter u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .round_sel(round_sel),
        .state_in(state_in), .state_out(state_out), .done(done)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int k);
        logic [W-1:0] r;
        for (int j = 0; j < W; j++) r[j] = v[(j + k) % W];
        return r;
    endfunction

    function automatic int sbox_at(input int idx);
        int tbl [32] = '{4,11,31,20,26,21,9,2,27,5,8,18,29,3,6,28,
                         30,19,7,14,0,13,17,24,16,12,1,25,22,10,15,23};
        return tbl[idx];
    endfunction

    function automatic logic [SW-1:0] ref_round(input logic [SW-1:0] s, input int r);
        logic [W-1:0] w [5];
        logic [W-1:0] o [5];
        int ra [5] = '{19, 61, 1, 10, 7};
        int rb [5] = '{28, 39, 6, 17, 41};
        logic [SW-1:0] res;
        for (int i = 0; i < 5; i++) w[i] = s[i*W +: W];
        w[2] = w[2] ^ W'(((15 - r) * 16) + r);
        for (int b = 0; b < W; b++) begin
            int idx = 0;
            int v;
            for (int i = 0; i < 5; i++) idx = idx * 2 + int'(w[i][b]);
            v = sbox_at(idx);
            for (int i = 0; i < 5; i++) o[i][b] = v[4 - i];
        end
        for (int i = 0; i < 5; i++)
            res[i*W +: W] = o[i] ^ rotr(o[i], ra[i]) ^ rotr(o[i], rb[i]);
        return res;
    endfunction

    function automatic int count_of(input logic [1:0] c);
        return (c == 2'b01) ? 8 : (c == 2'b10) ? 6 : 12;
    endfunction

    int            m_phase = 0;   // 0 waiting, 1 rounds, 2 finished
    int            m_idx = 0;
    logic [SW-1:0] m_state = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0;
            m_idx = 0;
            m_state = '0;
        end else if (m_phase == 1) begin
            m_state = ref_round(m_state, m_idx);
            if (m_idx == 11) m_phase = 2;
            m_idx++;
        end else if (start) begin
            m_state = state_in;
            m_idx = 12 - count_of(round_sel);
            m_phase = 1;
        end else begin
            m_phase = 0;
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (state_out !== m_state) begin
                errors++;
                $display("FAIL R2 R4 R5 R6 state_out act=%h exp=%h", state_out, m_state);
            end
            checks++;
            if (done !== (m_phase == 2)) begin
                errors++;
                $display("FAIL R7 done act=%b exp=%b", done, m_phase == 2);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [SW-1:0] act,
                         input logic [SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] pattern(input int seed);
        logic [SW-1:0] p;
        for (int i = 0; i < 10; i++) p[i*32 +: 32] = 32'h9E3779B9 * (seed + i + 1) ^ (seed << i);
        return p;
    endfunction

    // start a run and count cycles until done is seen
    task automatic launch(input logic [1:0] code, input logic [SW-1:0] v, output int cnt);
        round_sel = code;
        state_in = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic finish_up;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int n;
        logic [SW-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done === 1'b0, "R1 done", SW'(done), '0);
        check(state_out === '0, "R1 state_out", state_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R7 each round-count code
        for (int c = 0; c < 4; c++) begin
            launch(2'(c), pattern(c), n);
            check(n == count_of(2'(c)), "R3 R7 round count", SW'(n), SW'(count_of(2'(c))));
            @(negedge clk);
            check(done === 1'b0, "R7 single-cycle done", SW'(done), '0);
        end

        // R4 R5 R6 all-zero and all-one states through full and short runs
        launch(2'b00, '0, n);
        check(n == 12, "R4 zero state 12 rounds", SW'(n), SW'(12));
        launch(2'b10, '1, n);
        check(n == 6, "R4 ones state 6 rounds", SW'(n), SW'(6));

        // R8 hold after done while state_in changes
        held = state_out;
        for (int k = 0; k < 4; k++) begin
            state_in = pattern(50 + k);
            @(negedge clk);
            check(state_out === held, "R8 hold", state_out, held);
        end

        // R9 start in the middle of a run is ignored
        round_sel = 2'b01;
        state_in = pattern(7);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        round_sel = 2'b10;
        state_in = pattern(99);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 4;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == 8, "R9 ignored mid-run start", SW'(n), SW'(8));

        // R10 start presented in the done cycle
        launch(2'b01, pattern(11), n);
        launch(2'b10, pattern(12), n);
        check(n == 6, "R10 restart in done cycle", SW'(n), SW'(6));
        launch(2'b00, pattern(13), n);
        check(n == 12, "R10 second back-to-back", SW'(n), SW'(12));

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule